// File: doc/BRIEF.md
# Instruction Prefetch Window

This block sits between instruction memory and the decode stage of a small byte-oriented processor. It reads bytes in address order from a byte-wide memory port and keeps them in a circular window of `DEPTH` entries, 16 by default. It shows the dispatcher the opcode at the head of the window, the two bytes after it, the instruction length and the program counter of that opcode. When every byte of the head instruction is present, the whole instruction goes out in a single cycle, and a new one can follow on every cycle after that.

There are two ways to empty the window. A taken branch does it with a redirect strobe and a target address: the window refills from the target, and the first instruction there appears only once enough bytes have come back from memory. A write port snoops memory stores. A store that lands on a byte already held in the window throws away the held bytes and fetches again from the oldest instruction not yet dispatched. Code that patches itself therefore never runs a stale copy.

Length decode uses a reduced opcode rule that looks only at the two low bits of the opcode.

Top module: `instr_prefetch_buf`

## Requirements
- R1: After reset the window is empty, `instValid` is 0, `fetchAddr` equals the `RESET_PC` parameter (0 by default) and `fetchReq` is 1.
- R2: The instruction length is taken from opcode bits [1:0]: 00 gives 1 byte, 01 gives 2, 10 gives 3 and 11 gives 1. It is presented on `instLen`.
- R3: `instValid` is 1 exactly when the number of held bytes is at least the head instruction's length and `stall` is 0. `instBytes[7:0]` holds the opcode, `[15:8]` the first operand and `[23:16]` the second. `instPc` is the address of the opcode.
- R4: A cycle with `instValid` and `consume` both high dispatches the instruction. On the next cycle `instPc` has advanced by its length. Dispatch can happen on every consecutive cycle while enough bytes are held.
- R5: `fetchReq` is 1 when fewer than `DEPTH` bytes are held and no flush happens in that cycle. Each cycle with `fetchReq` and `fetchAck` both high stores `fetchData` and advances `fetchAddr` by one. A full window stops requesting.
- R6: A `redirect` pulse drops `fetchReq` in that cycle. On the next cycle the window is empty and `fetchAddr` and `instPc` both equal `redirectAddr`.
- R7: A snooped store (`snoopWe`) whose address lies within the held bytes (base up to base+count-1, modulo the address width) empties the window. Fetching restarts at the address of the oldest instruction not dispatched, which includes any dispatch in the same cycle. The bytes fetched again show the stored value.
- R8: A snooped store outside the held bytes, including the address one past the last held byte, changes neither the window contents nor `instPc`.
- R9: When `redirect` coincides with a snoop hit and a dispatch, the redirect wins and fetching continues from `redirectAddr`.
- R10: While `stall` is 1, `instValid` is 0 and `consume` has no effect. The head instruction remains for later dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchReq | output | 1 | Byte read request to memory |
| fetchAddr | output | AW | Address of the requested byte |
| fetchData | input | 8 | Byte returned for `fetchAddr` |
| fetchAck | input | 1 | Memory accepts the request and returns `fetchData` in this cycle |
| stall | input | 1 | Pipeline stall, blocks dispatch |
| consume | input | 1 | Dispatcher takes the presented instruction |
| instValid | output | 1 | A complete instruction is presented |
| instLen | output | 2 | Length of the presented instruction (1 to 3) |
| instBytes | output | 24 | Opcode and two following bytes |
| instPc | output | AW | Address of the presented opcode |
| redirect | input | 1 | Taken branch, flush and refetch |
| redirectAddr | input | AW | Branch target |
| snoopWe | input | 1 | Memory store observed |
| snoopAddr | input | AW | Address of the observed store |

## Verification
`instValid`, `instLen`, `instBytes`, `instPc` and `fetchReq` are combinational from the window state and the current inputs. They are due in the same cycle the inputs are applied. Dispatch, fill, redirect and store flushes change that state at the next rising edge, so their effects are due one cycle later. The bench drives inputs on the falling edge and samples one time unit later, and it expects flush results on the following falling edge. For each instruction it computes the required availability from the byte count `fetchAddr - expected PC` and from its own length table.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  // Control-to-datapath strobes for one cycle
  typedef struct packed {
    logic       redirect;    // branch flush
    logic       storeFlush;  // snooped store hit the window
    logic       push;        // a fetched byte enters at the tail
    logic       pop;         // head instruction dispatched
    logic [1:0] popLen;      // its length in bytes
  } pfbStrobes_t;

  // Reduced length rule: opcode bits [1:0]
  function automatic logic [1:0] opLength(input logic [7:0] op);
    case (op[1:0])
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pfb_datapath.sv
module pfb_datapath
  import pfb_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AW       = 16,
  parameter int RESET_PC = 0,
  localparam int PW      = $clog2(DEPTH),
  localparam int CW      = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pfbStrobes_t   strb,
  input  logic [AW-1:0] redirectAddr,
  input  logic [AW-1:0] snoopAddr,
  input  logic [7:0]    fetchData,
  output logic [CW-1:0] count,
  output logic          windowHit,
  output logic [23:0]   headBytes,
  output logic [AW-1:0] baseAddr,
  output logic [AW-1:0] fetchAddr
);

  logic [7:0]    store [DEPTH];
  logic [PW-1:0] head;
  logic [PW-1:0] tail;
  logic [AW-1:0] snoopOfs;
  logic [AW-1:0] restartAddr;
  logic [1:0]    popAmt;

  assign tail   = head + count[PW-1:0];
  assign popAmt = strb.pop ? strb.popLen : 2'd0;

  // Three-byte view starting at the head
  for (genvar k = 0; k < 3; k++) begin : g_win
    logic [PW-1:0] idx;
    assign idx = head + PW'(k);
    assign headBytes[8*k +: 8] = store[idx];
  end

  // Store snoop: offset from the oldest byte, compared with the fill level
  assign snoopOfs    = snoopAddr - baseAddr;
  assign windowHit   = (snoopOfs < AW'(count));
  assign restartAddr = baseAddr + AW'(popAmt);

  always_ff @(posedge clk) begin
    if (strb.push) store[tail] <= fetchData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      count     <= '0;
      baseAddr  <= AW'(RESET_PC);
      fetchAddr <= AW'(RESET_PC);
    end else if (strb.redirect) begin
      count     <= '0;
      baseAddr  <= redirectAddr;
      fetchAddr <= redirectAddr;
    end else if (strb.storeFlush) begin
      count     <= '0;
      baseAddr  <= restartAddr;
      fetchAddr <= restartAddr;
    end else begin
      head     <= head + PW'(popAmt);
      baseAddr <= restartAddr;
      count    <= count + CW'(strb.push) - CW'(popAmt);
      if (strb.push) fetchAddr <= fetchAddr + 1'b1;
    end
  end

endmodule

// File: rtl/pfb_control.sv
module pfb_control
  import pfb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          stall,
  input  logic          consume,
  input  logic          redirect,
  input  logic          snoopWe,
  input  logic          fetchAck,
  input  logic          windowHit,
  input  logic [CW-1:0] count,
  input  logic [7:0]    opcode,
  output pfbStrobes_t   strb,
  output logic          instValid,
  output logic [1:0]    instLen,
  output logic          fetchReq
);

  logic storeFlush;

  assign instLen    = opLength(opcode);
  assign instValid  = (count >= CW'(instLen)) && !stall;
  assign storeFlush = !redirect && snoopWe && windowHit;
  assign fetchReq   = (count < CW'(DEPTH)) && !redirect && !storeFlush;

  always_comb begin
    strb.redirect   = redirect;
    strb.storeFlush = storeFlush;
    strb.push       = fetchReq && fetchAck;
    strb.pop        = instValid && consume;
    strb.popLen     = instLen;
  end

endmodule

// File: rtl/instr_prefetch_buf.sv
module instr_prefetch_buf
  import pfb_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AW       = 16,
  parameter int RESET_PC = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          fetchReq,
  output logic [AW-1:0] fetchAddr,
  input  logic [7:0]    fetchData,
  input  logic          fetchAck,
  input  logic          stall,
  input  logic          consume,
  output logic          instValid,
  output logic [1:0]    instLen,
  output logic [23:0]   instBytes,
  output logic [AW-1:0] instPc,
  input  logic          redirect,
  input  logic [AW-1:0] redirectAddr,
  input  logic          snoopWe,
  input  logic [AW-1:0] snoopAddr
);

  localparam int CW = $clog2(DEPTH) + 1;

  pfbStrobes_t   strb;
  logic [CW-1:0] count;
  logic          windowHit;

  pfb_control #(.DEPTH(DEPTH)) u_ctrl (
    .stall     (stall),
    .consume   (consume),
    .redirect  (redirect),
    .snoopWe   (snoopWe),
    .fetchAck  (fetchAck),
    .windowHit (windowHit),
    .count     (count),
    .opcode    (instBytes[7:0]),
    .strb      (strb),
    .instValid (instValid),
    .instLen   (instLen),
    .fetchReq  (fetchReq)
  );

  pfb_datapath #(.DEPTH(DEPTH), .AW(AW), .RESET_PC(RESET_PC)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .redirectAddr (redirectAddr),
    .snoopAddr    (snoopAddr),
    .fetchData    (fetchData),
    .count        (count),
    .windowHit    (windowHit),
    .headBytes    (instBytes),
    .baseAddr     (instPc),
    .fetchAddr    (fetchAddr)
  );

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetchReq,
  input logic          fetchAck,
  input logic [AW-1:0] fetchAddr,
  input logic          stall,
  input logic          consume,
  input logic          instValid,
  input logic [1:0]    instLen,
  input logic [AW-1:0] instPc,
  input logic          redirect,
  input logic [AW-1:0] redirectAddr,
  input logic          snoopWe
);

  a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    instValid |-> (instLen != 2'd0));

  a_r4_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && consume && !redirect && !snoopWe)
      |=> (instPc == $past(instPc) + AW'($past(instLen))));

  a_r5_seq_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchReq && fetchAck && !redirect && !snoopWe)
      |=> (fetchAddr == $past(fetchAddr) + 1'b1));

  a_r6_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!instValid && fetchAddr == $past(redirectAddr)
                  && instPc == $past(redirectAddr)));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !instValid);

endmodule

bind instr_prefetch_buf pfb_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetchReq     (fetchReq),
  .fetchAck     (fetchAck),
  .fetchAddr    (fetchAddr),
  .stall        (stall),
  .consume      (consume),
  .instValid    (instValid),
  .instLen      (instLen),
  .instPc       (instPc),
  .redirect     (redirect),
  .redirectAddr (redirectAddr),
  .snoopWe      (snoopWe)
);

// File: tb/instr_prefetch_buf_test.sv
module instr_prefetch_buf_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          fetchReq;
  logic [AW-1:0] fetchAddr;
  logic [7:0]    fetchData;
  logic          fetchAck;
  logic          stall = 0, consume = 0, redirect = 0, snoopWe = 0;
  logic          memReady = 0;
  logic [AW-1:0] redirectAddr = '0, snoopAddr = '0;
  logic [7:0]    snoopData = '0;
  logic          instValid;
  logic [1:0]    instLen;
  logic [23:0]   instBytes;
  logic [AW-1:0] instPc;

  logic [7:0] mem [256];
  int checks = 0, failures = 0, fires = 0;
  logic [AW-1:0] expPc;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fetchData = mem[fetchAddr[7:0]];
  assign fetchAck  = fetchReq & memReady;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'((i * 37 + 11) & 255);
    end else if (snoopWe) begin
      mem[snoopAddr[7:0]] <= snoopData;
    end
  end

  instr_prefetch_buf uut (.*);

  function automatic int expLen(input logic [7:0] op);
    case (op[1:0])
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 3;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Dispatch stream with per-cycle availability prediction (R2, R3, R4)
  task automatic runStream(input int n, input int readyMod);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      memReady = (readyMod == 0) ? 1'b1 : ((c % readyMod) != 0);
      consume  = 1;
      #1;
      begin
        int elen;
        logic [AW-1:0] avail;
        bit ev;
        logic [23:0] expB;
        elen  = expLen(mem[expPc[7:0]]);
        avail = fetchAddr - expPc;
        ev    = (int'(avail) >= elen) && !stall;
        check(instValid == ev, "R3 valid", instValid, ev);
        if (instValid && ev) begin
          expB = instBytes;
          for (int k = 0; k < elen; k++) expB[8*k +: 8] = mem[8'(expPc + AW'(k))];
          check(instPc == expPc, "R4 pc", instPc, expPc);
          check(int'(instLen) == elen, "R2 len", instLen, elen);
          check(instBytes == expB, "R3 bytes", instBytes, expB);
          expPc = expPc + AW'(elen);
          fires++;
        end
      end
    end
    @(negedge clk);
    consume = 0;
  endtask

  task automatic fillFull();
    @(negedge clk);
    consume = 0; memReady = 1;
    repeat (20) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(instValid == 0, "R1 valid", instValid, 0);
    check(fetchReq == 1, "R1 req", fetchReq, 1);
    check(fetchAddr == 0, "R1 addr", fetchAddr, 0);
  endtask

  task automatic t_fill();
    fillFull();
    check(fetchReq == 0, "R5 full", fetchReq, 0);
    check(fetchAddr == 16, "R5 addr", fetchAddr, 16);
    check(instValid == 1 && instPc == 0, "R3 head", instPc, 0);
    expPc = 0;
  endtask

  task automatic t_stall();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); stall = 1; consume = 1; #1;
      check(instValid == 0, "R10 stall", instValid, 0);
    end
    @(negedge clk); stall = 0; consume = 0; #1;
    check(instValid == 1 && instPc == expPc, "R10 kept", instPc, expPc);
  endtask

  task automatic t_stream();
    fires = 0;
    runStream(5, 0);
    check(fires == 5, "R4 back-to-back", fires, 5);
    runStream(40, 3);
    runStream(30, 0);
  endtask

  task automatic t_redirect();
    @(negedge clk); consume = 0; redirect = 1; redirectAddr = 16'h0080; #1;
    check(fetchReq == 0, "R6 req", fetchReq, 0);
    @(negedge clk); redirect = 0; #1;
    check(instValid == 0 && fetchAddr == 16'h0080, "R6 refetch", fetchAddr, 16'h0080);
    check(instPc == 16'h0080, "R6 pc", instPc, 16'h0080);
    expPc = 16'h0080;
    runStream(25, 0);
  endtask

  task automatic t_snoopMiss();
    logic [AW-1:0] p;
    fillFull();
    p = expPc;
    @(negedge clk); snoopWe = 1; snoopAddr = p + 16; snoopData = 8'h55;
    @(negedge clk); snoopWe = 0; #1;
    check(instValid == 1 && instPc == p, "R8 pc", instPc, p);
    check(fetchReq == 0 && fetchAddr == p + 16, "R8 window", fetchAddr, p + 16);
  endtask

  task automatic t_snoopHit();
    logic [AW-1:0] p;
    fillFull();
    p = expPc;
    @(negedge clk); snoopWe = 1; snoopAddr = p + 15; snoopData = 8'hA6;
    @(negedge clk); snoopWe = 0; #1;
    check(instValid == 0 && fetchAddr == p, "R7 restart", fetchAddr, p);
    runStream(30, 0);
  endtask

  task automatic t_snoopDispatch();
    logic [AW-1:0] p;
    int elen;
    fillFull();
    p = expPc;
    elen = expLen(mem[p[7:0]]);
    @(negedge clk); consume = 1; snoopWe = 1; snoopAddr = p; snoopData = 8'h02; #1;
    check(instValid == 1 && instPc == p, "R7 dispatch", instPc, p);
    @(negedge clk); consume = 0; snoopWe = 0; #1;
    check(instValid == 0 && fetchAddr == p + AW'(elen), "R7 same-cycle", fetchAddr, p + AW'(elen));
    expPc = p + AW'(elen);
    runStream(20, 0);
  endtask

  task automatic t_priority();
    logic [AW-1:0] p;
    fillFull();
    p = expPc;
    @(negedge clk); consume = 1; redirect = 1; redirectAddr = 16'h0020;
    snoopWe = 1; snoopAddr = p + 1; snoopData = 8'h11;
    @(negedge clk); consume = 0; redirect = 0; snoopWe = 0; #1;
    check(fetchAddr == 16'h0020 && instValid == 0, "R9 priority", fetchAddr, 16'h0020);
    expPc = 16'h0020;
    runStream(20, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill();
    t_stall();
    t_stream();
    t_redirect();
    t_snoopMiss();
    t_snoopHit();
    t_snoopDispatch();
    t_priority();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule